// File: doc/BRIEF.md
# MDIO Management Frame Master

This block lets software on a simple host bus run management accesses to SerDes PHY devices over a two-wire MDIO link. Software programs a control register with a preamble switch and an MDC divisor. It then writes a 32-bit command word into a second register. That write launches the transfer. The block generates MDC from the system clock, optionally sends a run of ones as preamble, and then shifts the command word out MSB first. For a read, it releases the line from the turnaround onward and captures the 16 data bits the PHY returns.

Software polls a done flag in the control register. For reads, it collects the result from the low half of the command register. Writing the control register at any time returns the block to idle.

The parameter `PAGED` chooses between two addressing schemes. In the direct scheme, the command word goes onto the wire exactly as written. In the paged scheme, the block first sends a page-select write frame that carries the target PHY number. It then sends the access itself with the PHY address field forced to zero.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset both registers read as zero, MDC is low and the MDIO output enable is low.
- R2: The control register is at offset 0x128 and the command register at 0x12C. In the control register, bit 7 enables the preamble, bits 3:0 hold the divisor, and bit 8 is a read-only done flag. The remaining bits read as zero.
- R3: MDC idles low and has a period of 2*(divisor+1) system clocks. MDIO output changes only at MDC falling edges, and input is sampled at MDC rising edges.
- R4: A frame is the 32-bit command word sent MSB first, so bit 31 goes out first. Software sets bits 31:30 to 01 (start) and bits 29:28 to 10 for a read or 01 for a write. Bits 27:18 carry the PHY and register address, bits 17:16 carry the turnaround 10, and bits 15:0 carry the write data.
- R5: With bit 7 set, every frame is preceded by 32 MDC cycles with MDIO driven to one. With bit 7 clear, no preamble is sent.
- R6: In a read frame the output enable is low from the turnaround (word bit 17) to the end of the frame. The 16 bits sampled MSB first replace bits 15:0 of the command register, and bits 31:16 are kept.
- R7: Bit 8 goes to 1 when the last frame of a command ends. It returns to 0 when a new command is accepted and on any control register write.
- R8: A command register write while a transfer is in progress is ignored. It changes neither the readback nor the frames on the wire.
- R9: A control register write during a transfer ends the transfer at once. On the next cycle MDC is low and the output enable is low, and bit 8 stays 0.
- R10: With `PAGED`=1, each command first sends a write frame to PHY 0, register 0x1F, with data equal to command bits 27:23 shifted left by 4. It then sends the command word with bits 27:23 forced to zero. With `PAGED`=0, only the command word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two functions can meet on a single clock edge. One is the end of a transfer, which sets done and frees the engine. The other is a host command write, which must be ignored while the engine is busy and accepted once it is idle. The bench provokes this by holding a second command write active on every cycle from the start of the first transfer until the readback shows the new word. That puts one write on the exact edge where the first frame ends and another on the edge right after it. The scoreboard must then see exactly the two expected frames in order, and the readback must show the first word unchanged until the second is accepted.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_W  = 32;              // bits per frame and per preamble
  localparam int IDX_W    = $clog2(FRAME_W);
  localparam int TA_POS   = 14;              // wire index of word bit 17
  localparam int DATA_POS = 16;              // wire index of word bit 15
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [4:0] PAGE_REG = 5'h1F;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_FRM  = 2'd2
  } eng_state_t;

  function automatic logic [31:0] page_select_word(input logic [4:0] phy);
    page_select_word = {2'b01, OP_WRITE, 5'd0, PAGE_REG, 2'b10, 7'd0, phy, 4'd0};
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             tick;

  assign tick   = run_i && !clear_i && (cnt_q == div_i);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run_i || clear_i) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  AST_HALF_PHASE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clear_i) |-> (cnt_q <= div_i)); // R3

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        abort_i,
  input  logic        pre_en_i,
  input  logic        two_frames_i,
  input  logic [31:0] first_word_i,
  input  logic [31:0] main_word_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rx_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

  eng_state_t       st_q, st_d;
  logic [IDX_W-1:0] bit_q, bit_d;
  logic [31:0]      frame_q, frame_d;
  logic             second_q, second_d;
  logic [15:0]      rx_q, rx_d;
  logic             done_d;
  logic [IDX_W-1:0] wire_pos;
  logic             rd_frame;

  assign wire_pos = LAST_IDX - bit_q;
  assign rd_frame = (frame_q[29:28] == OP_READ);

  always_comb begin
    st_d     = st_q;
    bit_d    = bit_q;
    frame_d  = frame_q;
    second_d = second_q;
    rx_d     = rx_q;
    done_d   = 1'b0;
    if (abort_i) begin
      st_d     = ST_IDLE;
      bit_d    = '0;
      second_d = 1'b0;
    end else if (st_q == ST_IDLE) begin
      if (start_i) begin
        frame_d  = first_word_i;
        second_d = two_frames_i;
        bit_d    = '0;
        st_d     = pre_en_i ? ST_PRE : ST_FRM;
      end
    end else begin
      if (rise_i && (st_q == ST_FRM) && rd_frame && (bit_q >= DAT_IDX))
        rx_d = {rx_q[14:0], mdio_i};
      if (fall_i) begin
        if (bit_q == LAST_IDX) begin
          bit_d = '0;
          if (st_q == ST_PRE) begin
            st_d = ST_FRM;
          end else if (second_q) begin
            second_d = 1'b0;
            frame_d  = main_word_i;
            st_d     = pre_en_i ? ST_PRE : ST_FRM;
          end else begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      bit_q    <= '0;
      frame_q  <= '0;
      second_q <= 1'b0;
      rx_q     <= '0;
    end else begin
      st_q     <= st_d;
      bit_q    <= bit_d;
      frame_q  <= frame_d;
      second_q <= second_d;
      rx_q     <= rx_d;
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_d;
  assign rx_o      = rx_q;
  assign mdio_o    = (st_q == ST_FRM) ? frame_q[wire_pos] : 1'b1;
  assign mdio_oe_o = (st_q != ST_IDLE) &&
                     !((st_q == ST_FRM) && rd_frame && (bit_q >= TA_IDX));

  AST_NO_EDGE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !(rise_i || fall_i)); // R3
  AST_DONE_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (st_q == ST_FRM) && fall_i); // R7

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter int              DIV_W    = 4,
  parameter bit              PAGED    = 1'b0,
  parameter logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(12'h128),
  parameter logic [ADDR_W-1:0] CMD_OFS  = ADDR_W'(12'h12C)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam int DONE_BIT = 8;
  localparam int PRE_BIT  = 7;

  logic [1:0]       rst_pipe;
  logic             rst_q_n;
  logic             pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             done_q, done_d;
  logic [31:0]      cmd_q, cmd_d;
  logic             wr_ctrl, wr_cmd, accept;
  logic             busy, done_pulse, rise, fall;
  logic [15:0]      rx_data;
  logic [31:0]      first_word, main_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  assign wr_ctrl = bus_wr && (bus_addr == CTRL_OFS);
  assign wr_cmd  = bus_wr && (bus_addr == CMD_OFS);
  assign accept  = wr_cmd && !busy;

  generate
    if (PAGED) begin : g_paged
      assign first_word = page_select_word(bus_wdata[27:23]);
      assign main_word  = {cmd_q[31:28], 5'd0, cmd_q[22:0]};
    end else begin : g_direct
      assign first_word = bus_wdata;
      assign main_word  = cmd_q;
    end
  endgenerate

  always_comb begin
    pre_d  = pre_q;
    div_d  = div_q;
    done_d = done_q;
    cmd_d  = cmd_q;
    if (wr_ctrl) begin
      pre_d  = bus_wdata[PRE_BIT];
      div_d  = bus_wdata[DIV_W-1:0];
      done_d = 1'b0;
    end else if (accept) begin
      cmd_d  = bus_wdata;
      done_d = 1'b0;
    end else if (done_pulse) begin
      done_d = 1'b1;
      if (cmd_q[29:28] == OP_READ) cmd_d[15:0] = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pre_q  <= 1'b0;
      div_q  <= '0;
      done_q <= 1'b0;
      cmd_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        pre_q <= pre_d;
        div_q <= div_d;
      end
      if (wr_ctrl || accept || done_pulse) begin
        done_q <= done_d;
        cmd_q  <= cmd_d;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFS) begin
      bus_rdata[DONE_BIT]    = done_q;
      bus_rdata[PRE_BIT]     = pre_q;
      bus_rdata[DIV_W-1:0]   = div_q;
    end else if (bus_addr == CMD_OFS) begin
      bus_rdata = cmd_q;
    end
  end

  mdio_clk_div #(.DIV_W(DIV_W)) clk_div_i (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .run_i   (busy),
    .clear_i (wr_ctrl),
    .div_i   (div_q),
    .mdc_o   (mdc),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  mdio_frame_engine engine_i (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .start_i      (accept),
    .abort_i      (wr_ctrl),
    .pre_en_i     (pre_q),
    .two_frames_i (PAGED),
    .first_word_i (first_word),
    .main_word_i  (main_word),
    .rise_i       (rise),
    .fall_i       (fall),
    .mdio_i       (mdio_i),
    .busy_o       (busy),
    .done_o       (done_pulse),
    .rx_o         (rx_data),
    .mdio_o       (mdio_o),
    .mdio_oe_o    (mdio_oe)
  );

  AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_cmd && busy && !done_pulse && !wr_ctrl) |=> $stable(cmd_q)); // R8
  AST_DONE_CLEARED_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_q_n)
    accept |=> !done_q); // R7
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_ctrl |=> (!busy && !mdc && !mdio_oe && !done_q)); // R9
  AST_MDC_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy |-> !mdc); // R3
  AST_LINE_HELD_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(done_q) |-> $past(busy)); // R7

endmodule

// File: tb/mdio_phy_model.sv
module mdio_phy_model (
  input  logic        mdc,
  input  logic        mdio_o,
  input  logic        mdio_oe,
  output logic        mdio_i,
  output int          frames,
  output logic [31:0] last_word,
  output int          oe_err
);

  logic        in_frame;
  logic        is_read;
  int          idx;
  logic [31:0] word;
  logic [15:0] rdv;
  logic        b;

  function automatic logic [15:0] phy_value(input logic [9:0] a);
    phy_value = {a, 6'b101101} ^ 16'h5A3C;
  endfunction

  initial begin
    mdio_i = 1'b1; frames = 0; last_word = '0; oe_err = 0;
    in_frame = 1'b0; is_read = 1'b0; idx = 0; word = '0; rdv = '0;
  end

  always @(posedge mdc) begin
    if (!in_frame) begin
      if (mdio_oe && !mdio_o) begin
        in_frame = 1'b1; is_read = 1'b0; word = '0; idx = 1;
      end
    end else begin
      if (is_read && idx >= 14) begin
        if (mdio_oe) oe_err++;
        b = (idx >= 16) ? mdio_i : (idx == 14);
      end else begin
        if (!mdio_oe) oe_err++;
        b = mdio_o;
      end
      word[31-idx] = b;
      if (idx == 3)  is_read = (word[29:28] == 2'b10);
      if (idx == 13) rdv = phy_value(word[27:18]);
      idx++;
      if (idx == 32) begin
        last_word = word;
        in_frame  = 1'b0;
        is_read   = 1'b0;
        frames++;
      end
    end
  end

  always @(negedge mdc) begin
    if (in_frame && is_read && idx >= 16 && idx < 32) mdio_i = rdv[31-idx];
    else mdio_i = 1'b1;
  end

endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;

  localparam logic [11:0] CTRL = 12'h128;
  localparam logic [11:0] CMD  = 12'h12C;

  logic clk, rst_n, wr_p, wr_l;
  logic [11:0] addr;
  logic [31:0] wdata, rdata_p, rdata_l;
  logic mdc_p, mdo_p, oe_p, mdi_p;
  logic mdc_l, mdo_l, oe_l, mdi_l;
  int frames_p, frames_l, oerr_p, oerr_l;
  logic [31:0] lw_p, lw_l;
  int n_run, n_fail, edges_p, edges_l;
  bit finished;
  logic [31:0] exp_p[$], exp_l[$];
  string tag_p[$], tag_l[$];
  logic [31:0] e_p, e_l;
  string t_p, t_l;

  initial clk = 1'b0;
  always #10 clk = !clk;

  mdio_mgmt_master #(.PAGED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_p), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata_p), .mdc(mdc_p), .mdio_o(mdo_p), .mdio_oe(oe_p), .mdio_i(mdi_p));
  mdio_mgmt_master #(.PAGED(1'b0)) dut_leg_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_l), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata_l), .mdc(mdc_l), .mdio_o(mdo_l), .mdio_oe(oe_l), .mdio_i(mdi_l));

  mdio_phy_model phy_p_i (.mdc(mdc_p), .mdio_o(mdo_p), .mdio_oe(oe_p), .mdio_i(mdi_p),
    .frames(frames_p), .last_word(lw_p), .oe_err(oerr_p));
  mdio_phy_model phy_l_i (.mdc(mdc_l), .mdio_o(mdo_l), .mdio_oe(oe_l), .mdio_i(mdi_l),
    .frames(frames_l), .last_word(lw_l), .oe_err(oerr_l));

  function automatic logic [15:0] pv(input logic [9:0] a);
    pv = {a, 6'b101101} ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] sel_word(input logic [4:0] phy);
    sel_word = {4'b0101, 5'd0, 5'h1F, 2'b10, 7'd0, phy, 4'd0};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin edges_p = 0; edges_l = 0; end
  always @(posedge mdc_p) edges_p++;
  always @(posedge mdc_l) edges_l++;

  // scoreboard monitors
  always @(frames_p) if (frames_p > 0) begin
    if (exp_p.size() == 0) check(1'b0, "R8 unexpected frame", lw_p, 32'hx);
    else begin e_p = exp_p.pop_front(); t_p = tag_p.pop_front(); check(lw_p == e_p, t_p, lw_p, e_p); end
  end
  always @(frames_l) if (frames_l > 0) begin
    if (exp_l.size() == 0) check(1'b0, "R8 unexpected frame", lw_l, 32'hx);
    else begin e_l = exp_l.pop_front(); t_l = tag_l.pop_front(); check(lw_l == e_l, t_l, lw_l, e_l); end
  end

  task automatic push(input bit sel, input logic [31:0] w, input string tag);
    if (sel) begin exp_p.push_back(w); tag_p.push_back(tag); end
    else begin exp_l.push_back(w); tag_l.push_back(tag); end
  endtask

  task automatic bus_write(input bit sel, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (sel) wr_p = 1'b1; else wr_l = 1'b1;
    @(negedge clk);
    wr_p = 1'b0; wr_l = 1'b0;
  endtask

  task automatic bus_read(input bit sel, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = sel ? rdata_p : rdata_l;
  endtask

  task automatic wait_done(input bit sel);
    logic [31:0] r;
    for (int i = 0; i < 4000; i++) begin
      bus_read(sel, CTRL, r);
      if (r[8]) break;
    end
    check(r[8] == 1'b1, "R7 done set", r, r | 32'h100);
  endtask

  task automatic measure_period(input real exp_ns);
    realtime t0, t1;
    @(posedge mdc_l); t0 = $realtime;
    @(posedge mdc_l); t1 = $realtime;
    check((t1 - t0) > exp_ns - 0.5 && (t1 - t0) < exp_ns + 0.5, "R3 mdc period",
          32'(int'(t1 - t0)), 32'(int'(exp_ns)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, w, rd_cmd, exp_rd;
    int base, fbase, mism;
    n_run = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; wr_p = 1'b0; wr_l = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(0, CTRL, r); check(r == 0, "R1 ctrl reset", r, 0);
    bus_read(0, CMD, r);  check(r == 0, "R1 cmd reset", r, 0);
    bus_read(1, CTRL, r); check(r == 0, "R1 paged ctrl reset", r, 0);
    check({mdc_l, oe_l, mdc_p, oe_p} == 4'b0, "R1 pins idle", {mdc_l, oe_l, mdc_p, oe_p}, 0);

    // R2 control fields, done read-only
    bus_write(0, CTRL, 32'h1FF);
    bus_read(0, CTRL, r); check(r == 32'h08F, "R2 ctrl fields", r, 32'h08F);
    bus_write(0, CTRL, 32'h082);
    bus_read(0, CTRL, r); check(r == 32'h082, "R2 ctrl readback", r, 32'h082);

    // R4/R5/R10 direct write frame with preamble
    w = {4'b0101, 10'h0C6, 2'b10, 16'hBEEF};
    push(0, w, "R4 write frame");
    base = edges_l;
    bus_write(0, CMD, w);
    measure_period(120.0);
    wait_done(0);
    check(edges_l - base == 64, "R5 preamble edges", edges_l - base, 64);
    bus_read(0, CMD, r); check(r == w, "R10 direct readback", r, w);

    // R7 control write clears done
    bus_write(0, CTRL, 32'h002);
    bus_read(0, CTRL, r); check(r == 32'h002, "R7 ctrl write clears done", r, 32'h002);

    // R6 read without preamble
    rd_cmd = {4'b0110, 10'h2B3, 2'b10, 16'h0};
    exp_rd = {rd_cmd[31:16], pv(10'h2B3)};
    push(0, exp_rd, "R6 read frame");
    base = edges_l;
    bus_write(0, CMD, rd_cmd);
    wait_done(0);
    check(edges_l - base == 32, "R5 no preamble edges", edges_l - base, 32);
    bus_read(0, CMD, r); check(r == exp_rd, "R6 read data", r, exp_rd);
    check(oerr_l == 0, "R6 release window", oerr_l, 0);

    // R7 accept clears done
    w = {4'b0101, 10'h155, 2'b10, 16'h0F0F};
    push(0, w, "R4 write frame 2");
    bus_write(0, CMD, w);
    bus_read(0, CTRL, r); check(r[8] == 1'b0, "R7 accept clears done", r, 32'h002);
    wait_done(0);

    // R3 divisor zero
    bus_write(0, CTRL, 32'h080);
    w = {4'b0101, 10'h3FF, 2'b10, 16'h8001};
    push(0, w, "R4 write frame div0");
    bus_write(0, CMD, w);
    measure_period(40.0);
    wait_done(0);

    // R8 command write while busy ignored
    bus_write(0, CTRL, 32'h002);
    w = {4'b0101, 10'h011, 2'b10, 16'h1357};
    push(0, w, "R8 first frame");
    bus_write(0, CMD, w);
    repeat (10) @(negedge clk);
    bus_write(0, CMD, {4'b0110, 10'h222, 2'b10, 16'h0});
    bus_read(0, CMD, r); check(r == w, "R8 busy write ignored", r, w);
    wait_done(0);
    bus_read(0, CMD, r); check(r == w, "R8 readback after done", r, w);
    repeat (300) @(negedge clk);

    // R9 abort during preamble
    bus_write(0, CTRL, 32'h082);
    fbase = frames_l;
    bus_write(0, CMD, {4'b0101, 10'h0AA, 2'b10, 16'hAAAA});
    repeat (20) @(negedge clk);
    bus_write(0, CTRL, 32'h082);
    check({mdc_l, oe_l} == 2'b00, "R9 pins idle after abort", {mdc_l, oe_l}, 0);
    bus_read(0, CTRL, r); check(r == 32'h082, "R9 no done after abort", r, 32'h082);
    repeat (500) @(negedge clk);
    check(frames_l == fbase, "R9 no frame after abort", frames_l, fbase);

    // R10 paged write
    bus_write(1, CTRL, 32'h002);
    w = {4'b0101, 5'd9, 5'h0C, 2'b10, 16'h1234};
    push(1, sel_word(5'd9), "R10 page select");
    push(1, {4'b0101, 5'd0, 5'h0C, 2'b10, 16'h1234}, "R10 paged access");
    bus_write(1, CMD, w);
    wait_done(1);
    bus_read(1, CMD, r); check(r == w, "R10 paged write readback", r, w);

    // R10/R6 paged read with preamble
    bus_write(1, CTRL, 32'h082);
    rd_cmd = {4'b0110, 5'd17, 5'h03, 2'b10, 16'h0};
    push(1, sel_word(5'd17), "R10 page select read");
    push(1, {4'b0110, 5'd0, 5'h03, 2'b10, pv({5'd0, 5'h03})}, "R6 paged read frame");
    base = edges_p;
    bus_write(1, CMD, rd_cmd);
    wait_done(1);
    check(edges_p - base == 128, "R5 paged preamble edges", edges_p - base, 128);
    exp_rd = {rd_cmd[31:16], pv({5'd0, 5'h03})};
    bus_read(1, CMD, r); check(r == exp_rd, "R10 paged read data", r, exp_rd);
    check(oerr_p == 0, "R6 paged release window", oerr_p, 0);

    // R8/R7 command write landing on the end of a transfer
    bus_write(0, CTRL, 32'h002);
    w = {4'b0101, 10'h0F0, 2'b10, 16'hCAFE};
    push(0, w, "R8 frame before collision");
    push(0, {4'b0101, 10'h30F, 2'b10, 16'hD00D}, "R7 frame after collision");
    bus_write(0, CMD, w);
    @(negedge clk);
    addr = CMD; wdata = {4'b0101, 10'h30F, 2'b10, 16'hD00D}; wr_l = 1'b1;
    mism = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if (rdata_l == wdata) break;
      if (rdata_l != w) mism++;
    end
    wr_l = 1'b0;
    check(mism == 0, "R8 held during collision", mism, 0);
    check(rdata_l == wdata, "R7 accepted after end", rdata_l, wdata);
    wait_done(0);

    repeat (50) @(negedge clk);
    check(exp_l.size() == 0, "R4 all direct frames seen", exp_l.size(), 0);
    check(exp_p.size() == 0, "R10 all paged frames seen", exp_p.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule